// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block joins two data ports, called A and B, with one storage channel per direction. The A-to-B channel drives the B port and the B-to-A channel drives the A port. Each channel can work in one of three ways. It can pass its input straight through, it can hold a value at a steady level, or it can load a new value on a strobe edge. The latch-enable level and the strobe edge together pick the mode.

Everything runs in one system clock domain. Each strobe input passes through a two-flop synchroniser and then an edge detector. The two directions have output enables of opposite polarity. There are no tri-state pins: each port gives out a data bus and a registered drive flag. A contention output rises when both drive flags are set at the same time.

Top module: `ubr_top`

## Requirements
- R1: While a channel's latch enable is high, its output bus equals its input bus in the same cycle, whatever the strobe does.
- R2: While the latch enable is low and no strobe rising edge is detected, the output bus keeps its previous value. This includes a strobe held steady high or steady low.
- R3: With the latch enable low, a strobe rising edge is handled as follows. The strobe is sampled high at clock edge k after being low at edge k-1. At edge k+2 the channel stores the input present at that edge, and the output shows it from then on.
- R4: When the latch enable falls while the strobe is already high, the output holds the input value sampled at the last clock edge with the latch enable still high.
- R5: The A-to-B output enable is active high. The B drive flag equals that enable as sampled at the previous clock edge.
- R6: The B-to-A output enable is active low. The A drive flag is the inverse of that enable as sampled at the previous clock edge.
- R7: The output enable gates only the drive flag. Storage keeps loading while the drive flag is low, and the stored value shows on the data bus.
- R8: Synchronous reset clears both stores to zero and clears both drive flags. With the latch enable low, both output buses then read zero.
- R9: The contention flag is high exactly when both drive flags are high.
- R10: The two channels are independent. Controls and data of one direction never change the other direction's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving at port A (source of the A-to-B channel) |
| b_in | input | 18 | Data arriving at port B (source of the B-to-A channel) |
| le_ab | input | 1 | A-to-B latch enable, high = pass-through |
| strb_ab | input | 1 | A-to-B load strobe, asynchronous |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, high = pass-through |
| strb_ba | input | 1 | B-to-A load strobe, asynchronous |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data presented on port B |
| b_drv | output | 1 | Port B drive flag |
| a_out | output | 18 | Data presented on port A |
| a_drv | output | 1 | Port A drive flag |
| contention | output | 1 | Both ports driven at once |

## Verification
The assertions check the following on every cycle:
- pass-through while the latch enable is high;
- the store staying stable when no edge is detected;
- the store taking the input in the cycle after a detected edge;
- the drive flags following their enables one cycle later;
- the clearing done by reset;
- the sources of the contention flag.

Only the bench scenarios can show the things that need chosen input sequences. These are the exact two-cycle latency from a strobe edge to a visible load, the value kept when the latch enable falls under a high strobe, and loading while the drive flag is low. The same applies to the independence of the two directions, because the assertions look at one channel at a time.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

  // Operating mode of one storage channel in a given cycle
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,  // latch enable high: store tracks input
    MODE_HOLD = 2'd1,  // latch enable low, no edge: keep value
    MODE_LOAD = 2'd2   // latch enable low, strobe edge: take input
  } ubr_mode_e;

  function automatic ubr_mode_e mode_of(input logic le, input logic rise);
    if (le)        return MODE_PASS;
    else if (rise) return MODE_LOAD;
    else           return MODE_HOLD;
  endfunction

endpackage

// File: rtl/ubr_strobe_edge.sv
module ubr_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  // Synchroniser chain; the last stage feeds the edge detector
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], strobe_i};
      prev_q <= sync_q[TOP];
    end
  end

  assign rise_o = sync_q[TOP] & ~prev_q;

  // A detected edge lasts exactly one cycle
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R3

endmodule

// File: rtl/ubr_channel.sv
module ubr_channel #(
  parameter int W             = 18,
  parameter int SYNC_STAGES   = 2,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         strobe,
  input  logic         oe,
  output logic [W-1:0] dout,
  output logic         drv
);
  import ubr_pkg::*;

  logic         strobe_rise;
  logic         oe_active;
  ubr_mode_e    mode;
  logic [W-1:0] store_q;
  logic [W-1:0] store_d;
  logic         drv_q;

  ubr_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe),
    .rise_o   (strobe_rise)
  );

  // Enable polarity is chosen per direction
  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign oe_active = ~oe;
    end else begin : g_oe_high
      assign oe_active = oe;
    end
  endgenerate

  function automatic logic [W-1:0] next_store(input ubr_mode_e m,
                                              input logic [W-1:0] d,
                                              input logic [W-1:0] s);
    case (m)
      MODE_PASS, MODE_LOAD: return d;
      default:              return s;
    endcase
  endfunction

  function automatic logic [W-1:0] view(input logic l,
                                        input logic [W-1:0] d,
                                        input logic [W-1:0] s);
    return l ? d : s;
  endfunction

  assign mode    = mode_of(le, strobe_rise);
  assign store_d = next_store(mode, din, store_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      drv_q   <= 1'b0;
    end else begin
      store_q <= store_d;
      drv_q   <= oe_active;
    end
  end

  assign dout = view(le, din, store_q);
  assign drv  = drv_q;

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!le && !strobe_rise) |=> $stable(store_q)); // R2

  AST_LOAD_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!le && strobe_rise) |=> (store_q == $past(din))); // R3

  AST_TRACK_OPEN: assert property (@(posedge clk) disable iff (rst)
    le |=> (store_q == $past(din))); // R4

  AST_DRV_ON: assert property (@(posedge clk) disable iff (rst)
    oe_active |=> drv); // R5

  AST_DRV_OFF: assert property (@(posedge clk) disable iff (rst)
    !oe_active |=> !drv); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (store_q == '0 && !drv)); // R8

endmodule

// File: rtl/ubr_top.sv
module ubr_top #(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         le_ab,
  input  logic         strb_ab,
  input  logic         oe_ab,
  input  logic         le_ba,
  input  logic         strb_ba,
  input  logic         oe_ba_n,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic         contention
);

  // A-to-B direction, enable active high
  ubr_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk    (clk),
    .rst    (rst),
    .din    (a_in),
    .le     (le_ab),
    .strobe (strb_ab),
    .oe     (oe_ab),
    .dout   (b_out),
    .drv    (b_drv)
  );

  // B-to-A direction, enable active low
  ubr_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk    (clk),
    .rst    (rst),
    .din    (b_in),
    .le     (le_ba),
    .strobe (strb_ba),
    .oe     (oe_ba_n),
    .dout   (a_out),
    .drv    (a_drv)
  );

  assign contention = a_drv & b_drv;

  AST_PASS_AB: assert property (@(posedge clk) disable iff (rst)
    le_ab |-> (b_out == a_in)); // R1

  AST_PASS_BA: assert property (@(posedge clk) disable iff (rst)
    le_ba |-> (a_out == b_in)); // R1

  AST_CONTENTION_SRC: assert property (@(posedge clk) disable iff (rst)
    contention |-> ($past(oe_ab) && !$past(oe_ba_n))); // R9

endmodule

// File: tb/ubr_top_bench.sv
`timescale 1ns/1ps
module ubr_top_bench;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         le_ab = 1'b0, strb_ab = 1'b0, oe_ab = 1'b0;
  logic         le_ba = 1'b0, strb_ba = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic         b_drv, a_drv, contention;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ubr_top #(.W(W)) u_ubr_top (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .le_ab(le_ab), .strb_ab(strb_ab), .oe_ab(oe_ab),
    .le_ba(le_ba), .strb_ba(strb_ba), .oe_ba_n(oe_ba_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
    .contention(contention)
  );

  // Fields: [37] latch enable, [36] strobe, [35:18] input, [17:0] expected
  localparam logic [37:0] VEC [8] = '{
    {1'b1, 1'b0, 18'h12345, 18'h12345},  // R1 pass
    {1'b1, 1'b1, 18'h0ABCD, 18'h0ABCD},  // R1 pass with strobe high
    {1'b0, 1'b1, 18'h3FFFF, 18'h0ABCD},  // R4 close under high strobe
    {1'b0, 1'b0, 18'h15555, 18'h0ABCD},  // R2 steady low
    {1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA},  // R3 edge load
    {1'b0, 1'b1, 18'h00001, 18'h2AAAA},  // R2 steady high
    {1'b0, 1'b0, 18'h00F0F, 18'h2AAAA},  // R2 strobe falls
    {1'b0, 1'b1, 18'h00F0F, 18'h00F0F}   // R3 second load
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R8 reset state
    check("R8 b_out after reset", b_out, '0);
    check("R8 a_out after reset", a_out, '0);
    check("R8 b_drv after reset", {17'd0, b_drv}, '0);
    check("R8 a_drv after reset", {17'd0, a_drv}, '0);

    // Table walk, both directions, B-to-A fed with inverted data
    for (int i = 0; i < 8; i++) begin
      le_ab = VEC[i][37]; strb_ab = VEC[i][36]; a_in = VEC[i][35:18];
      le_ba = VEC[i][37]; strb_ba = VEC[i][36]; b_in = ~VEC[i][35:18] & MASK;
      tick(4);
      check($sformatf("R1R2R3R4 vec %0d A-to-B", i), b_out, VEC[i][17:0]);
      check($sformatf("R1R2R3R4 vec %0d B-to-A", i), a_out, ~VEC[i][17:0] & MASK);
    end

    // R3 exact latency: strobe seen at edge k, load at edge k+2
    strb_ab = 1'b0; le_ab = 1'b0; tick(4);
    strb_ab = 1'b1; a_in = 18'h11111; tick(1);
    a_in = 18'h22222; tick(1);
    check("R3 no load one edge after sync", b_out, 18'h00F0F);
    a_in = 18'h33333; tick(1);
    check("R3 load at edge k+2", b_out, 18'h33333);
    a_in = 18'h04444; tick(2);
    check("R3 held after load", b_out, 18'h33333);

    // R10 B-to-A store untouched by A-to-B activity
    check("R10 B-to-A unchanged", a_out, ~18'h00F0F & MASK);

    // R5, R6, R9 drive flags
    oe_ab = 1'b1; tick(1);
    check("R5 b_drv follows enable", {17'd0, b_drv}, 18'd1);
    check("R6 a_drv off while enable high", {17'd0, a_drv}, '0);
    check("R9 no contention", {17'd0, contention}, '0);
    oe_ba_n = 1'b0; tick(1);
    check("R6 a_drv on for low enable", {17'd0, a_drv}, 18'd1);
    check("R9 contention raised", {17'd0, contention}, 18'd1);
    oe_ab = 1'b0; tick(1);
    check("R5 b_drv dropped", {17'd0, b_drv}, '0);
    check("R9 contention cleared", {17'd0, contention}, '0);

    // R7 load while not driving
    strb_ab = 1'b0; a_in = 18'h2BEEF; tick(4);
    strb_ab = 1'b1; tick(4);
    check("R7 load while disabled", b_out, 18'h2BEEF);
    check("R7 drive still off", {17'd0, b_drv}, '0);

    // R8 mid-run reset with latch enables low
    strb_ab = 1'b0; strb_ba = 1'b0; oe_ab = 1'b1;
    rst = 1'b1; tick(2);
    rst = 1'b0;
    check("R8 b_out cleared", b_out, '0);
    check("R8 a_out cleared", a_out, '0);
    check("R8 a_drv cleared", {17'd0, a_drv}, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule